// File: doc/BRIEF.md
# Receive Carrier Loss Detector

This block watches a received dual-rail line, one bit time at a time, and decides whether a carrier is present. A single-cycle strobe qualifies each bit time. In that cycle the positive and negative rail inputs are sampled together. A bit time with a mark on either rail is a one. A bit time with no mark on either rail is a zero.

The loss alarm is a level. It rises once an unbroken run of zero bit times reaches a selectable length: 255 or 2048. It falls only when the line shows enough ones density again. While the alarm is up, the strobed bit times are grouped into back-to-back, non-overlapping windows of 255. The alarm drops at the end of the first window that held at least 32 ones.

A one-cycle change pulse goes with every rise and every fall of the level. A status and interrupt block can therefore latch both directions. Clock recovery, line decoding and every other alarm belong to neighbouring blocks.

Top module: `rx_carrier_loss`

## Requirements
- R1: While reset is applied and in the first cycle after it, `loss_alarm` and `loss_change` are 0.
- R2: A strobed bit time counts as a one when `rail_p` is 1, when `rail_n` is 1, or when both are 1. It counts as a zero only when both rails are 0.
- R3: With `long_sel` = 0, `loss_alarm` rises in the cycle after the strobe that completes 255 consecutive zero bit times. A run of 254 zeros does not raise it.
- R4: With `long_sel` = 1, the alarm rises after 2048 consecutive zero bit times. A run of 2047 zeros does not raise it.
- R5: Any strobed one restarts the count of consecutive zeros from zero.
- R6: While the alarm is set, windows of 255 strobed bit times start with the first strobe after the rise. The alarm falls in the cycle after the strobe that closes a window holding 32 or more ones.
- R7: A window holding 31 ones or fewer leaves the alarm set. Ones are never carried from one window into the next.
- R8: `loss_change` is 1 for exactly the one cycle in which `loss_alarm` first shows a new value, for rises and for falls, and is 0 otherwise.
- R9: In cycles without `bit_stb`, the rail inputs are ignored: neither output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | Marks the cycle that carries one received bit time |
| rail_p | input | 1 | Positive rail mark, sampled with `bit_stb` |
| rail_n | input | 1 | Negative rail mark, sampled with `bit_stb` |
| long_sel | input | 1 | 0: 255-zero set threshold, 1: 2048-zero set threshold |
| loss_alarm | output | 1 | Carrier loss level |
| loss_change | output | 1 | One-cycle pulse on every change of `loss_alarm` |

## Verification
The bench builds the block with its default parameters: run thresholds of 255 and 2048, a 255-bit clear window and a 32-ones clear threshold. The default thresholds are small enough that both run lengths, and several full clear windows, fit into a few thousand strobes. The bench can therefore probe the exact off-by-one edges without scaled-down values. These edges are 254 against 255 zeros, 2047 against 2048, and 31 against 32 ones in a window. It also places ones on both sides of a window boundary, and runs part of the traffic with gapped strobes while the rails toggle between strobes.

// File: rtl/rx_cl_pkg.sv
package rx_cl_pkg;

   typedef enum logic {
      CL_CARRIER_OK   = 1'b0,
      CL_CARRIER_LOST = 1'b1
   } cl_state_e;

   function automatic int unsigned cl_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rx_cl_zero_run.sv
module rx_cl_zero_run #(
   parameter int unsigned SHORT_RUN = 255,
   parameter int unsigned LONG_RUN  = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic is_one,
   input  logic long_sel,
   output logic run_hit
);
   import rx_cl_pkg::*;

   localparam int unsigned RUN_MAX = cl_max(SHORT_RUN, LONG_RUN);
   localparam int unsigned CW      = $clog2(RUN_MAX + 1);

   logic [CW-1:0] cnt_q, cnt_d, thr;
   logic          at_thr;

   generate
      if (SHORT_RUN == LONG_RUN) begin : g_single_thr
         logic unused_sel;
         assign unused_sel = long_sel;
         assign thr        = CW'(SHORT_RUN);
      end else begin : g_dual_thr
         assign thr = long_sel ? CW'(LONG_RUN) : CW'(SHORT_RUN);
      end
   endgenerate

   always_comb begin
      at_thr = (cnt_q >= thr);
      if (!stb) begin
         cnt_d = cnt_q;
      end else if (is_one) begin
         cnt_d = '0;
      end else if (at_thr) begin
         cnt_d = thr;
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
      run_hit = stb && !is_one && (cnt_d >= thr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   // R5: a strobed one restarts the run
   a_r5_one_restarts_run: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && is_one) |=> (cnt_q == '0));

   // R9: the run count only moves on a strobe
   a_r9_run_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(cnt_q));

   // R3 / R4: the counter never exceeds the larger threshold
   a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(RUN_MAX));

endmodule

// File: rtl/rx_cl_ones_window.sv
module rx_cl_ones_window #(
   parameter int unsigned WIN_LEN  = 255,
   parameter int unsigned ONES_MIN = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic stb,
   input  logic is_one,
   output logic win_pass
);

   localparam int unsigned PW = $clog2(WIN_LEN);
   localparam int unsigned OW = $clog2(ONES_MIN + 1);

   logic [PW-1:0] pos_q, pos_d;
   logic [OW-1:0] ones_q, ones_d, ones_nxt;
   logic          last_bit;

   always_comb begin
      last_bit = (pos_q == PW'(WIN_LEN - 1));
      if (is_one && (ones_q < OW'(ONES_MIN))) begin
         ones_nxt = ones_q + 1'b1;
      end else begin
         ones_nxt = ones_q;
      end
      win_pass = active && stb && last_bit && (ones_nxt >= OW'(ONES_MIN));

      if (!active) begin
         pos_d  = '0;
         ones_d = '0;
      end else if (stb) begin
         if (last_bit) begin
            pos_d  = '0;
            ones_d = '0;
         end else begin
            pos_d  = pos_q + 1'b1;
            ones_d = ones_nxt;
         end
      end else begin
         pos_d  = pos_q;
         ones_d = ones_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         ones_q <= '0;
      end else begin
         pos_q  <= pos_d;
         ones_q <= ones_d;
      end
   end

   // R6: the window position stays inside the window
   a_r6_pos_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q < PW'(WIN_LEN));

   // R6: a window starts fresh while no alarm is pending
   a_r6_idle_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (pos_q == '0 && ones_q == '0));

   // R7: no ones are carried across a window boundary
   a_r7_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (active && stb && last_bit) |=> (ones_q == '0));

endmodule

// File: rtl/rx_cl_alarm_ctl.sv
module rx_cl_alarm_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic alarm,
   output logic change
);
   import rx_cl_pkg::*;

   cl_state_e st_q, st_d;
   logic      chg_q, chg_d;

   always_comb begin
      st_d  = st_q;
      chg_d = 1'b0;
      unique case (st_q)
         CL_CARRIER_OK: begin
            if (set_req) begin
               st_d  = CL_CARRIER_LOST;
               chg_d = 1'b1;
            end
         end
         CL_CARRIER_LOST: begin
            if (clr_req) begin
               st_d  = CL_CARRIER_OK;
               chg_d = 1'b1;
            end
         end
         default: st_d = CL_CARRIER_OK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CL_CARRIER_OK;
         chg_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         chg_q <= chg_d;
      end
   end

   assign alarm  = (st_q == CL_CARRIER_LOST);
   assign change = chg_q;

   // R8: a change pulse never lasts two cycles
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      change |=> !change);

endmodule

// File: rtl/rx_carrier_loss.sv
module rx_carrier_loss #(
   parameter int unsigned SHORT_RUN = 255,
   parameter int unsigned LONG_RUN  = 2048,
   parameter int unsigned WIN_LEN   = 255,
   parameter int unsigned ONES_MIN  = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic rail_p,
   input  logic rail_n,
   input  logic long_sel,
   output logic loss_alarm,
   output logic loss_change
);

   generate
      if (SHORT_RUN < 2) begin : g_bad_short
         $error("SHORT_RUN must be at least 2");
      end
      if (LONG_RUN < 2) begin : g_bad_long
         $error("LONG_RUN must be at least 2");
      end
      if (WIN_LEN < 2) begin : g_bad_win
         $error("WIN_LEN must be at least 2");
      end
      if (ONES_MIN < 1 || ONES_MIN > WIN_LEN) begin : g_bad_ones
         $error("ONES_MIN must lie in 1..WIN_LEN");
      end
   endgenerate

   logic is_one;
   logic run_hit;
   logic win_pass;

   assign is_one = rail_p | rail_n;

   rx_cl_zero_run #(
      .SHORT_RUN (SHORT_RUN),
      .LONG_RUN  (LONG_RUN)
   ) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (bit_stb),
      .is_one   (is_one),
      .long_sel (long_sel),
      .run_hit  (run_hit)
   );

   rx_cl_ones_window #(
      .WIN_LEN  (WIN_LEN),
      .ONES_MIN (ONES_MIN)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (loss_alarm),
      .stb      (bit_stb),
      .is_one   (is_one),
      .win_pass (win_pass)
   );

   rx_cl_alarm_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (run_hit),
      .clr_req (win_pass),
      .alarm   (loss_alarm),
      .change  (loss_change)
   );

   // R8: the pulse marks exactly the cycles where the level moved
   a_r8_change_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
      loss_change == (loss_alarm != $past(loss_alarm)));

   // R9: without a strobe neither output moves
   a_r9_idle_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |=> ($stable(loss_alarm) && !loss_change));

   // R2 / R3: only a strobed zero bit time can raise the alarm
   a_r3_rise_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!loss_alarm && !(bit_stb && !rail_p && !rail_n)) |=> !loss_alarm);

   // R6: the alarm only falls at the close of a passing window
   a_r6_fall_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
      (loss_alarm && !win_pass) |=> loss_alarm);

endmodule

// File: tb/rx_carrier_loss_test.sv
module rx_carrier_loss_test;

   localparam int SHORT_RUN = 255;
   localparam int LONG_RUN  = 2048;
   localparam int WIN_LEN   = 255;
   localparam int ONES_MIN  = 32;

   typedef struct {
      bit    alarm;
      bit    chg;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_stb = 1'b0;
   logic rail_p = 1'b0;
   logic rail_n = 1'b0;
   logic long_sel = 1'b0;
   logic loss_alarm;
   logic loss_change;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 1'b0;
   string phase   = "R1";

   exp_t exp_q[$];

   // reference state built from the requirements
   int   m_run   = 0;
   int   m_pos   = 0;
   int   m_ones  = 0;
   bit   m_alarm = 1'b0;

   always #10 clk = ~clk;

   rx_carrier_loss #(
      .SHORT_RUN (SHORT_RUN),
      .LONG_RUN  (LONG_RUN),
      .WIN_LEN   (WIN_LEN),
      .ONES_MIN  (ONES_MIN)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_stb     (bit_stb),
      .rail_p      (rail_p),
      .rail_n      (rail_n),
      .long_sel    (long_sel),
      .loss_alarm  (loss_alarm),
      .loss_change (loss_change)
   );

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   // driver: one call per clock, pushes the expected outputs for that edge
   task automatic tick(input bit s, input bit p, input bit n);
      exp_t e;
      bit   one;
      bit   old;
      int   thr;
      @(negedge clk);
      bit_stb = s;
      rail_p  = p;
      rail_n  = n;
      old = m_alarm;
      if (s) begin
         one = p | n;
         thr = long_sel ? LONG_RUN : SHORT_RUN;
         if (one) m_run = 0;
         else if (m_run >= thr) m_run = thr;
         else m_run++;
         if (!m_alarm) begin
            if (!one && m_run >= thr) begin
               m_alarm = 1'b1;
               m_pos   = 0;
               m_ones  = 0;
            end
         end else begin
            m_pos++;
            if (one) m_ones++;
            if (m_pos == WIN_LEN) begin
               if (m_ones >= ONES_MIN) m_alarm = 1'b0;
               m_pos  = 0;
               m_ones = 0;
            end
         end
      end
      e.alarm = m_alarm;
      e.chg   = (m_alarm != old);
      e.tag   = phase;
      exp_q.push_back(e);
   endtask

   task automatic bits(input int count, input bit p, input bit n, input int gap);
      for (int i = 0; i < count; i++) begin
         tick(1'b1, p, n);
         for (int g = 0; g < gap; g++) tick(1'b0, 1'b1, 1'b1);
      end
   endtask

   // one clear window of WIN_LEN bits; ones placed by mode
   // mode 0: k ones at the end, mode 1: k ones at the start, mode 2: every 7th bit
   task automatic window(input int k, input int mode);
      int placed = 0;
      for (int i = 0; i < WIN_LEN; i++) begin
         bit one;
         case (mode)
            0: one = (i >= WIN_LEN - k);
            1: one = (i < k);
            default: one = ((i % 7) == 0) && (placed < k);
         endcase
         if (one) placed++;
         tick(1'b1, one, 1'b0);
      end
   endtask

   task automatic expect_level(input bit exp, input string tag);
      tick(1'b0, 1'b0, 1'b0);
      @(posedge clk);
      #3;
      check(loss_alarm === exp, tag, "loss_alarm level", int'(loss_alarm), int'(exp));
   endtask

   // monitor: compares each edge's outputs with the queued expectation
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(loss_alarm === e.alarm, e.tag, "loss_alarm", int'(loss_alarm), int'(e.alarm));
            check(loss_change === e.chg, {e.tag, " R8"}, "loss_change", int'(loss_change), int'(e.chg));
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check(loss_alarm === 1'b0, "R1", "alarm in reset", int'(loss_alarm), 0);
      check(loss_change === 1'b0, "R1", "change in reset", int'(loss_change), 0);
      rst_n = 1'b1;
      phase = "R1";
      tick(1'b0, 1'b0, 1'b0);

      // R2 / R5: marks on either rail break the run
      phase = "R2_R5";
      bits(200, 1'b0, 1'b0, 0);
      bits(1, 1'b1, 1'b0, 0);
      bits(254, 1'b0, 1'b0, 0);
      bits(1, 1'b0, 1'b1, 0);
      bits(254, 1'b0, 1'b0, 1);
      bits(1, 1'b1, 1'b1, 0);
      bits(254, 1'b0, 1'b0, 0);
      expect_level(1'b0, "R3 254 zeros");

      // R3: the 255th zero raises the alarm
      phase = "R3";
      bits(1, 1'b0, 1'b0, 0);
      expect_level(1'b1, "R3 255 zeros");

      // R7: 31 ones at a window end, then 31 at the next start
      phase = "R7";
      window(31, 0);
      window(31, 1);
      expect_level(1'b1, "R7 split ones");

      // R9: idle cycles with marks on the rails
      phase = "R9";
      for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, 1'b1);
      expect_level(1'b1, "R9 idle marks");

      // R6: 32 ones in one window clear the alarm
      phase = "R6";
      window(32, 2);
      expect_level(1'b0, "R6 32 ones");

      // R4: long threshold
      phase = "R4";
      long_sel = 1'b1;
      bits(1, 1'b1, 1'b0, 0);
      bits(2047, 1'b0, 1'b0, 0);
      expect_level(1'b0, "R4 2047 zeros");
      bits(1, 1'b0, 1'b1, 0);
      bits(2048, 1'b0, 1'b0, 0);
      expect_level(1'b1, "R4 2048 zeros");

      // R6 with gapped strobes: a window of all ones
      phase = "R6_gap";
      bits(WIN_LEN, 1'b1, 1'b0, 2);
      expect_level(1'b0, "R6 gapped window");

      tick(1'b0, 1'b0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule